// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

The block is a word-addressed static memory with two independent ports, A and B. Each port has its own clock. Either port can read or write any word, and both ports may use the same word in the same cycle. Each port keeps an address register that also works as a burst counter. On every rising edge of the port clock, that register is cleared, loaded from the external address, advanced by one, or held. The memory access in that cycle uses the register's new value, so a burst needs only one external address followed by advance strobes.

Each port is selected only when its active-low and active-high chip enables are both asserted, which lets several copies be stacked in depth. A per-port mode input picks flow-through reads, where data appears in the cycle after the edge that sampled the access, or pipelined reads, which add one register stage. The tri-state data bus is modelled as a data output plus an output-valid flag. The flag is raised only for a read issued while selected and only while output enable is high. When the flag is low, the data output is zero.

The depth is 2^ADDR_W words: ADDR_W of 15, 16 or 17 gives 32K, 64K or 128K words. DATA_W is 8 or 9. The defaults are kept small.

Top module: `dp_burst_ram`

## Requirements
- R1: On each port edge the address register takes zero when clear is high, else the external address when load is high, else its value plus one when advance is high, else it holds. The access in that cycle uses this new value.
- R2: Advancing from the highest address gives address zero.
- R3: With mode low (flow-through), a read sampled at edge k drives valid high and the word's data from just after edge k until edge k+1.
- R4: With mode high (pipelined), a read sampled at edge k drives valid high and the word's data from just after edge k+1 until edge k+2.
- R5: A port is selected only when its active-low enable is 0 and its active-high enable is 1. A write while unselected leaves memory unchanged, and a read while unselected leaves valid low.
- R6: Valid is low and data is zero whenever output enable is low, and in the flow-through cycle that follows a write.
- R7: A read on one port of the word that the other port writes at the same edge returns the old contents. The next read returns the new value.
- R8: When both ports write the same word at the same edge, the word afterwards holds one of the two written values.
- R9: Every word written through one port reads back the same value through the other port.
- R10: While reset is low, both address registers are zero, both valid flags are low and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_a_i | input | 1 | Port A clock |
| ce0_n_a_i | input | 1 | Port A enable, active low |
| ce1_a_i | input | 1 | Port A enable, active high |
| we_a_i | input | 1 | Port A write (1) or read (0) |
| oe_a_i | input | 1 | Port A output enable |
| pipe_a_i | input | 1 | Port A pipelined read mode |
| ld_a_i | input | 1 | Port A load address register |
| inc_a_i | input | 1 | Port A advance address register |
| clr_a_i | input | 1 | Port A clear address register |
| addr_a_i | input | ADDR_W | Port A external address |
| wdata_a_i | input | DATA_W | Port A write data |
| rdata_a_o | output | DATA_W | Port A read data |
| rvalid_a_o | output | 1 | Port A output valid |
| clk_b_i | input | 1 | Port B clock |
| ce0_n_b_i | input | 1 | Port B enable, active low |
| ce1_b_i | input | 1 | Port B enable, active high |
| we_b_i | input | 1 | Port B write (1) or read (0) |
| oe_b_i | input | 1 | Port B output enable |
| pipe_b_i | input | 1 | Port B pipelined read mode |
| ld_b_i | input | 1 | Port B load address register |
| inc_b_i | input | 1 | Port B advance address register |
| clr_b_i | input | 1 | Port B clear address register |
| addr_b_i | input | ADDR_W | Port B external address |
| wdata_b_i | input | DATA_W | Port B write data |
| rdata_b_o | output | DATA_W | Port B read data |
| rvalid_b_o | output | 1 | Port B output valid |

## Verification
A wrong address register value shows up in the next read of a burst. The bench writes a distinct value to every word, so a skipped, repeated or wrongly wrapped address produces a mismatch one cycle after the faulty edge in flow-through mode and two cycles after it in pipelined mode. A corrupted bank, or a write that reaches a bank while the port is unselected, surfaces on the first later read of that word from either port. A stage or valid bit out of step shows as valid or data shifted by exactly one cycle against the mode's latency.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD,
    CTR_INC,
    CTR_LOAD,
    CTR_CLR
  } ctr_op_e;
endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic [ADDR_W-1:0] cnt_o
);
  ctr_op_e           op;
  logic [ADDR_W-1:0] cnt_q;

  always_comb begin
    if (clr_i)      op = CTR_CLR;
    else if (ld_i)  op = CTR_LOAD;
    else if (inc_i) op = CTR_INC;
    else            op = CTR_HOLD;
  end

  always_comb begin
    unique case (op)
      CTR_CLR:  nxt_o = '0;
      CTR_LOAD: nxt_o = addr_i;
      CTR_INC:  nxt_o = cnt_q + ADDR_W'(1);  // wraps at 2**ADDR_W
      default:  nxt_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic              pipe_i,
  input  logic              ld_i,
  input  logic              inc_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wd_o,
  output logic [ADDR_W-1:0] cnt_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              sel;
  logic              rd_issue;
  logic              v1_q, v2_q;
  logic [DATA_W-1:0] d2_q;
  logic              v_mux;
  logic [DATA_W-1:0] d_mux;

  dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .ld_i   (ld_i),
    .inc_i  (inc_i),
    .addr_i (addr_i),
    .nxt_o  (mem_addr_o),
    .cnt_o  (cnt_o)
  );

  assign sel      = !ce0_n_i && ce1_i;
  assign rd_issue = sel && !we_i;
  assign mem_we_o = sel && we_i;
  assign mem_wd_o = wdata_i;

  // stage 1 data lives in the core read register; stage 2 here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      d2_q <= '0;
    end else begin
      v1_q <= rd_issue;
      v2_q <= v1_q;
      d2_q <= mem_rd_i;
    end
  end

  assign v_mux    = pipe_i ? v2_q : v1_q;
  assign d_mux    = pipe_i ? d2_q : mem_rd_i;
  assign rvalid_o = v_mux && oe_i;
  assign rdata_o  = rvalid_o ? d_mux : '0;
endmodule

// File: rtl/dpr_xor_core.sv
module dpr_xor_core #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              rst_ni,
  input  logic              clk_a_i,
  input  logic              we_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wd_a_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic              clk_b_i,
  input  logic              we_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] rd_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // word = bank_a ^ bank_b; each bank has a single writer clock
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic              b_wins;

  // same word written by both ports: A yields so the word ends as B's value
  assign b_wins = we_b_i && (addr_b_i == addr_a_i);

  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) bank_a[i] <= '0;
      rd_a_o <= '0;
    end else begin
      if (we_a_i && !b_wins) bank_a[addr_a_i] <= wd_a_i ^ bank_b[addr_a_i];
      rd_a_o <= bank_a[addr_a_i] ^ bank_b[addr_a_i];
    end
  end

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) bank_b[i] <= '0;
      rd_b_o <= '0;
    end else begin
      if (we_b_i) bank_b[addr_b_i] <= wd_b_i ^ bank_a[addr_b_i];
      rd_b_o <= bank_a[addr_b_i] ^ bank_b[addr_b_i];
    end
  end
endmodule

// File: rtl/dp_burst_ram.sv
module dp_burst_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              rst_ni,
  input  logic              clk_a_i,
  input  logic              ce0_n_a_i,
  input  logic              ce1_a_i,
  input  logic              we_a_i,
  input  logic              oe_a_i,
  input  logic              pipe_a_i,
  input  logic              ld_a_i,
  input  logic              inc_a_i,
  input  logic              clr_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              rvalid_a_o,
  input  logic              clk_b_i,
  input  logic              ce0_n_b_i,
  input  logic              ce1_b_i,
  input  logic              we_b_i,
  input  logic              oe_b_i,
  input  logic              pipe_b_i,
  input  logic              ld_b_i,
  input  logic              inc_b_i,
  input  logic              clr_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              rvalid_b_o
);
  logic              mwe_a, mwe_b;
  logic [ADDR_W-1:0] maddr_a, maddr_b;
  logic [DATA_W-1:0] mwd_a, mwd_b, mrd_a, mrd_b;
  logic [ADDR_W-1:0] cnt_a, cnt_b;

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .ce0_n_i    (ce0_n_a_i),
    .ce1_i      (ce1_a_i),
    .we_i       (we_a_i),
    .oe_i       (oe_a_i),
    .pipe_i     (pipe_a_i),
    .ld_i       (ld_a_i),
    .inc_i      (inc_a_i),
    .clr_i      (clr_a_i),
    .addr_i     (addr_a_i),
    .wdata_i    (wdata_a_i),
    .mem_rd_i   (mrd_a),
    .mem_we_o   (mwe_a),
    .mem_addr_o (maddr_a),
    .mem_wd_o   (mwd_a),
    .cnt_o      (cnt_a),
    .rdata_o    (rdata_a_o),
    .rvalid_o   (rvalid_a_o)
  );

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
    .clk_i      (clk_b_i),
    .rst_ni     (rst_ni),
    .ce0_n_i    (ce0_n_b_i),
    .ce1_i      (ce1_b_i),
    .we_i       (we_b_i),
    .oe_i       (oe_b_i),
    .pipe_i     (pipe_b_i),
    .ld_i       (ld_b_i),
    .inc_i      (inc_b_i),
    .clr_i      (clr_b_i),
    .addr_i     (addr_b_i),
    .wdata_i    (wdata_b_i),
    .mem_rd_i   (mrd_b),
    .mem_we_o   (mwe_b),
    .mem_addr_o (maddr_b),
    .mem_wd_o   (mwd_b),
    .cnt_o      (cnt_b),
    .rdata_o    (rdata_b_o),
    .rvalid_o   (rvalid_b_o)
  );

  dpr_xor_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .rst_ni   (rst_ni),
    .clk_a_i  (clk_a_i),
    .we_a_i   (mwe_a),
    .addr_a_i (maddr_a),
    .wd_a_i   (mwd_a),
    .rd_a_o   (mrd_a),
    .clk_b_i  (clk_b_i),
    .we_b_i   (mwe_b),
    .addr_b_i (maddr_b),
    .wd_b_i   (mwd_b),
    .rd_b_o   (mrd_b)
  );
endmodule

// File: rtl/dp_burst_ram_chk.sv
module dp_burst_ram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              rst_ni,
  input logic              clk_a_i,
  input logic              clk_b_i,
  input logic              clr_a_i,
  input logic              ld_a_i,
  input logic              inc_a_i,
  input logic [ADDR_W-1:0] addr_a_i,
  input logic [ADDR_W-1:0] cnt_a,
  input logic              clr_b_i,
  input logic              ld_b_i,
  input logic              inc_b_i,
  input logic [ADDR_W-1:0] addr_b_i,
  input logic [ADDR_W-1:0] cnt_b,
  input logic              ce0_n_a_i,
  input logic              ce1_a_i,
  input logic              we_a_i,
  input logic              pipe_a_i,
  input logic              rvalid_a_o,
  input logic              rvalid_b_o
);
  AST_CLR_ZERO_A: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    clr_a_i |=> (cnt_a == '0)); // R1
  AST_LOAD_ADDR_B: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!clr_b_i && ld_b_i) |=> (cnt_b == $past(addr_b_i))); // R1
  AST_INC_WRAP_A: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!clr_a_i && !ld_a_i && inc_a_i) |=> (cnt_a == ADDR_W'($past(cnt_a) + 1'b1))); // R2
  AST_HOLD_B: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!clr_b_i && !ld_b_i && !inc_b_i) |=> $stable(cnt_b)); // R1
  AST_WR_NO_VALID_A: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!ce0_n_a_i && ce1_a_i && we_a_i && !pipe_a_i) |=> (!rvalid_a_o || pipe_a_i)); // R6
  AST_RST_QUIET: assert property (@(posedge clk_b_i)
    !rst_ni |-> (!rvalid_a_o && !rvalid_b_o)); // R10
endmodule

bind dp_burst_ram dp_burst_ram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dp_burst_ram.sv
module sim_dp_burst_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic rst_ni, clk;
  logic ce0_n_a, ce1_a, we_a, oe_a, pipe_a, ld_a, inc_a, clr_a;
  logic ce0_n_b, ce1_b, we_b, oe_b, pipe_b, ld_b, inc_b, clr_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW-1:0] wd_a, wd_b, rd_a, rd_b;
  logic rv_a, rv_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [DEPTH];

  dp_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .ce0_n_a_i(ce0_n_a), .ce1_a_i(ce1_a), .we_a_i(we_a), .oe_a_i(oe_a),
    .pipe_a_i(pipe_a), .ld_a_i(ld_a), .inc_a_i(inc_a), .clr_a_i(clr_a),
    .addr_a_i(addr_a), .wdata_a_i(wd_a), .rdata_a_o(rd_a), .rvalid_a_o(rv_a),
    .clk_b_i(clk), .ce0_n_b_i(ce0_n_b), .ce1_b_i(ce1_b), .we_b_i(we_b), .oe_b_i(oe_b),
    .pipe_b_i(pipe_b), .ld_b_i(ld_b), .inc_b_i(inc_b), .clr_b_i(clr_b),
    .addr_b_i(addr_b), .wdata_b_i(wd_b), .rdata_b_o(rd_b), .rvalid_b_o(rv_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic sel, input logic we, input logic ld, input logic inc,
                      input logic clr, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    ce0_n_a = !sel; ce1_a = 1'b1; we_a = we; ld_a = ld; inc_a = inc; clr_a = clr;
    addr_a = ad; wd_a = wd;
  endtask

  task automatic b_op(input logic sel, input logic we, input logic ld, input logic inc,
                      input logic clr, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    ce0_n_b = !sel; ce1_b = 1'b1; we_b = we; ld_b = ld; inc_b = inc; clr_b = clr;
    addr_b = ad; wd_b = wd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat_f(input int j);
    return DW'(j * 5 + 1);
  endfunction

  function automatic logic [DW-1:0] pat_g(input int j);
    return DW'(j * 3 + 100);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    oe_a = 1'b1; oe_b = 1'b1; pipe_a = 1'b0; pipe_b = 1'b0;
    a_op(0, 0, 0, 0, 0, '0, '0);
    b_op(0, 0, 0, 0, 0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 valid a", DW'(rv_a), '0);
    chk("R10 valid b", DW'(rv_b), '0);
    chk("R10 data a", rd_a, '0);
    chk("R10 data b", rd_b, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: A writes all words via burst; first beat loads address 0
    for (int j = 0; j < DEPTH; j++) begin
      a_op(1, 1, j == 0, j != 0, 0, '0, pat_f(j));
      step();
      exp_mem[j] = pat_f(j);
      if (j == 3) chk("R6 no valid after write", DW'(rv_a), '0);
    end
    a_op(0, 0, 0, 0, 0, '0, '0);

    // R9 R3: B flow-through burst read
    for (int j = 0; j < DEPTH; j++) begin
      b_op(1, 0, j == 0, j != 0, 0, '0, '0);
      step();
      chk("R3 flow valid", DW'(rv_b), 1);
      chk("R9 B reads A data", rd_b, exp_mem[j]);
    end

    // B writes all words
    for (int j = 0; j < DEPTH; j++) begin
      b_op(1, 1, j == 0, j != 0, 0, '0, pat_g(j));
      step();
      exp_mem[j] = pat_g(j);
    end
    b_op(0, 0, 0, 0, 0, '0, '0);

    // R4 R9: A pipelined burst, data lags the issuing edge by one more cycle
    pipe_a = 1'b1;
    for (int j = 0; j <= DEPTH; j++) begin
      a_op(1, 0, j == 0, j != 0, 0, '0, '0);
      step();
      if (j == 0) chk("R4 no valid first cycle", DW'(rv_a), '0);
      else begin
        chk("R4 pipe valid", DW'(rv_a), 1);
        chk("R9 A reads B data", rd_a, exp_mem[j-1]);
      end
    end
    a_op(0, 0, 0, 0, 0, '0, '0);
    step();
    chk("R4 pipe tail valid", DW'(rv_a), 1);
    chk("R4 pipe tail data", rd_a, exp_mem[0]);
    pipe_a = 1'b0;
    step();

    // R2 wrap, R1 hold and priority (B flow)
    b_op(1, 0, 1, 0, 0, AW'(DEPTH - 1), '0); step();
    chk("R2 top word", rd_b, exp_mem[DEPTH-1]);
    b_op(1, 0, 0, 1, 0, '0, '0); step();
    chk("R2 wrap to zero", rd_b, exp_mem[0]);
    b_op(1, 0, 0, 1, 0, '0, '0); step();
    chk("R1 advance", rd_b, exp_mem[1]);
    b_op(1, 0, 0, 0, 0, AW'(77), '0); step();
    chk("R1 hold", rd_b, exp_mem[1]);
    b_op(1, 0, 1, 1, 1, AW'(5), '0); step();
    chk("R1 clear beats load", rd_b, exp_mem[0]);
    b_op(1, 0, 1, 1, 0, AW'(9), '0); step();
    chk("R1 load beats advance", rd_b, exp_mem[9]);
    b_op(1, 0, 0, 0, 1, '0, '0); step();
    chk("R1 clear", rd_b, exp_mem[0]);

    // R7: A writes word 20 while B reads it
    a_op(1, 1, 1, 0, 0, AW'(20), 9'h1AA);
    b_op(1, 0, 1, 0, 0, AW'(20), '0);
    step();
    chk("R7 old data", rd_b, exp_mem[20]);
    exp_mem[20] = 9'h1AA;
    a_op(0, 0, 0, 0, 0, '0, '0);
    b_op(1, 0, 0, 0, 0, '0, '0);
    step();
    chk("R7 new data", rd_b, exp_mem[20]);

    // R8: both write word 30
    a_op(1, 1, 1, 0, 0, AW'(30), 9'h011);
    b_op(1, 1, 1, 0, 0, AW'(30), 9'h022);
    step();
    a_op(0, 0, 0, 0, 0, '0, '0);
    b_op(1, 0, 0, 0, 0, '0, '0);
    step();
    checks++;
    if (rd_b !== 9'h011 && rd_b !== 9'h022) begin
      errors++;
      $display("FAIL R8 actual=%0h expected=11 or 22", rd_b);
    end
    exp_mem[30] = rd_b;

    // R5: write with either enable inactive has no effect
    a_op(1, 1, 1, 0, 0, AW'(40), 9'h155); ce0_n_a = 1'b1; step();
    a_op(1, 1, 1, 0, 0, AW'(41), 9'h0AA); ce1_a = 1'b0; step();
    a_op(0, 0, 0, 0, 0, '0, '0);
    b_op(1, 0, 1, 0, 0, AW'(40), '0); step();
    chk("R5 ce0 write ignored", rd_b, exp_mem[40]);
    b_op(1, 0, 0, 1, 0, '0, '0); step();
    chk("R5 ce1 write ignored", rd_b, exp_mem[41]);
    a_op(1, 0, 1, 0, 0, AW'(41), '0); ce1_a = 1'b0; step();
    chk("R5 unselected read", DW'(rv_a), '0);
    a_op(1, 0, 1, 0, 0, AW'(41), '0); ce0_n_a = 1'b1; step();
    chk("R5 unselected read ce0", DW'(rv_a), '0);

    // R6: output enable low
    a_op(1, 0, 1, 0, 0, AW'(41), '0); oe_a = 1'b0; step();
    chk("R6 oe low valid", DW'(rv_a), '0);
    chk("R6 oe low data", rd_a, '0);
    oe_a = 1'b1; #1;
    chk("R6 oe restored", rd_a, exp_mem[41]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule